// File: doc/BRIEF.md
# Machine State Register Write Controller

This block owns the processor's 32-bit machine state register and the side effects of writing it. A write arrives as a one-cycle strobe carrying the new value and a qualifier that says whether the write may change the hypervisor bit. The value is first filtered through a writable-bit mask. The hypervisor-bit protection rule is applied next. On a 64-bit server configuration, user mode then forces certain enable bits on. The result is committed on the same clock edge as every side effect.

The side effects are as follows. A one-cycle context-flush pulse fires when address-translation state changes. Four general registers are exchanged with four shadow registers when the shadow-select bit toggles. An exception-vector prefix register follows the exception-prefix bit. A halt request is raised when the power-save bit is written under the right conditions. The general registers have a plain write port and a combinational read port so that the surrounding core can use them. Each shadow register can be read at the same index.

Top module: `msr_write_ctrl`

## Requirements
- R1: After a synchronous reset the register holds the reset value (default 0x1000_0000: only the hypervisor bit, bit 28, is set). The prefix reads 0, halt and flush are low, and all eight bank registers read 0.
- R2: Every bit of a written value outside the writable mask (default 0x1806_C071) reads 0 after the write, except bits forced by R8. For example, writing bit 31 leaves it 0.
- R3: The hypervisor bit (28) takes the written value only if the alter qualifier is high and the current bit 28 is 1. Otherwise it keeps its old value.
- R4: ctx_flush is high for the one cycle after a write whose filtered value differs from the current register in the instruction-relocate bit (5) or the data-relocate bit (4). This comparison uses the value before the forcing of R8.
- R5: A change of the guest-state bit (27) also raises ctx_flush, but only when EMB_MMU is 1.
- R6: With SHADOW_EN set, a write that changes the shadow-select bit (17) exchanges general registers 0..3 with shadow registers 0..3 on the commit edge. A general-register write in that same cycle is dropped.
- R7: When a write changes the exception-prefix bit (6), the prefix becomes 0xFFF0_0000 if the new bit is 1 and 0x0000_0000 if it is 0.
- R8: With SERVER64 set, a write with the problem-state bit (14) set also sets bits 15, 5 and 4. With SERVER64 clear, nothing is forced.
- R9: Each write sets halt_req to (bit 18 of the new value) AND (irq_pending low) AND (pwr_allowed high), all sampled on the commit edge.
- R10: An asserted halt_req drops in the cycle after irq_pending is seen high, and is cleared by any write that does not meet R9.
- R11: The register, the prefix and halt_req change only on a cycle with wr_valid high (apart from R10's interrupt clear). Without a write, ctx_flush stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One-cycle write strobe |
| wr_data | input | 32 | Value to write |
| wr_alter_hv | input | 1 | Write may change the hypervisor bit |
| irq_pending | input | 1 | An interrupt is pending |
| pwr_allowed | input | 1 | Power-save entry permitted |
| gpr_we | input | 1 | General-register write enable |
| gpr_waddr | input | 2 | General-register write index |
| gpr_wdata | input | 32 | General-register write data |
| gpr_raddr | input | 2 | Read index for both banks |
| gpr_rdata | output | 32 | General register at read index |
| shd_rdata | output | 32 | Shadow register at read index |
| msr_q | output | 32 | Current machine state register |
| vec_prefix | output | 32 | Exception-vector prefix |
| ctx_flush | output | 1 | One-cycle translation-context flush |
| halt_req | output | 1 | Halt request |

## Verification
A table of writes walks the register through its main cases. These include an all-ones value, which shows the mask filtering and the side effects firing together. A clear with the hypervisor bit protected and a lone relocate enable are also in the table. A user-mode write with relocation off shows that the flush compares the value before forcing. Hypervisor writes with and without the current bit set separate the two halves of the protection rule. Directed sequences then do the following: fill the bank and toggle, hold and re-toggle the shadow select, with a colliding register write; sweep the interrupt and permission inputs around a power-save write; and compare a guest-state change on the default build against an embedded, non-server build.

// File: rtl/msrc_pkg.sv
`timescale 1ns/1ps
package msrc_pkg;
  localparam int MSR_W  = 32;
  localparam int B_HV   = 28;
  localparam int B_GS   = 27;
  localparam int B_POW  = 18;
  localparam int B_SHS  = 17;
  localparam int B_EE   = 15;
  localparam int B_PR   = 14;
  localparam int B_EP   = 6;
  localparam int B_IR   = 5;
  localparam int B_DR   = 4;
  localparam logic [MSR_W-1:0] FORCE_USER =
    (32'd1 << B_EE) | (32'd1 << B_IR) | (32'd1 << B_DR);
  localparam logic [MSR_W-1:0] PREFIX_HI = 32'hFFF0_0000;

  typedef struct packed {
    logic flush;
    logic swap;
    logic ep_chg;
  } msr_evt_t;
endpackage

// File: rtl/msrc_filter.sv
`timescale 1ns/1ps
module msrc_filter
  import msrc_pkg::*;
#(
  parameter logic [MSR_W-1:0] WMASK = 32'h1806_C071,
  parameter bit EMB_MMU   = 1'b0,
  parameter bit SERVER64  = 1'b1,
  parameter bit SHADOW_EN = 1'b1
) (
  input  logic [MSR_W-1:0] cur_msr,
  input  logic [MSR_W-1:0] wr_data,
  input  logic             alter_hv,
  output logic [MSR_W-1:0] nxt_msr,
  output msr_evt_t         evt
);
  logic [MSR_W-1:0] masked;
  logic [MSR_W-1:0] held;
  logic             hv_free;

  always_comb begin
    masked  = wr_data & WMASK;
    hv_free = alter_hv && cur_msr[B_HV];
    held    = masked;
    if (!hv_free) held[B_HV] = cur_msr[B_HV];

    evt.flush = (held[B_IR] ^ cur_msr[B_IR]) | (held[B_DR] ^ cur_msr[B_DR]);
    if (EMB_MMU) evt.flush = evt.flush | (held[B_GS] ^ cur_msr[B_GS]);
    evt.swap   = SHADOW_EN && (held[B_SHS] ^ cur_msr[B_SHS]);
    evt.ep_chg = held[B_EP] ^ cur_msr[B_EP];

    nxt_msr = held;
    if (SERVER64 && held[B_PR]) nxt_msr = held | FORCE_USER;
  end
endmodule

// File: rtl/msrc_bank.sv
`timescale 1ns/1ps
module msrc_bank #(
  parameter int NREG = 4,
  parameter int W    = 32,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swap_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  gpr_o,
  output logic [W-1:0]  shd_o
);
  logic [W-1:0] gpr_q [NREG];
  logic [W-1:0] shd_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        gpr_q[i] <= '0;
        shd_q[i] <= '0;
      end else if (swap_i) begin
        gpr_q[i] <= shd_q[i];
        shd_q[i] <= gpr_q[i];
      end else if (we_i && (waddr_i == AW'(i))) begin
        gpr_q[i] <= wdata_i;
      end
    end
  end

  assign gpr_o = gpr_q[raddr_i];
  assign shd_o = shd_q[raddr_i];

  // R6
  swap_moves_chk: assert property (@(posedge clk) disable iff (rst)
    swap_i |=> (gpr_q[0] == $past(shd_q[0])) && (shd_q[0] == $past(gpr_q[0])));
endmodule

// File: rtl/msrc_power.sv
`timescale 1ns/1ps
module msrc_power (
  input  logic clk,
  input  logic rst,
  input  logic wr_valid,
  input  logic pow_bit,
  input  logic irq_pending,
  input  logic pwr_allowed,
  output logic halt_o
);
  always_ff @(posedge clk) begin
    if (rst)           halt_o <= 1'b0;
    else if (wr_valid) halt_o <= pow_bit && !irq_pending && pwr_allowed;
    else if (irq_pending) halt_o <= 1'b0;
  end

  // R9
  halt_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_o) |-> $past(wr_valid) && $past(pwr_allowed) && !$past(irq_pending));
  // R10
  halt_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pending && !wr_valid) |=> !halt_o);
endmodule

// File: rtl/msr_write_ctrl.sv
`timescale 1ns/1ps
module msr_write_ctrl
  import msrc_pkg::*;
#(
  parameter logic [MSR_W-1:0] WMASK   = 32'h1806_C071,
  parameter logic [MSR_W-1:0] RST_MSR = 32'h1000_0000,
  parameter bit EMB_MMU   = 1'b0,
  parameter bit SERVER64  = 1'b1,
  parameter bit SHADOW_EN = 1'b1,
  parameter int NREG      = 4,
  localparam int AW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [MSR_W-1:0] wr_data,
  input  logic             wr_alter_hv,
  input  logic             irq_pending,
  input  logic             pwr_allowed,
  input  logic             gpr_we,
  input  logic [AW-1:0]    gpr_waddr,
  input  logic [MSR_W-1:0] gpr_wdata,
  input  logic [AW-1:0]    gpr_raddr,
  output logic [MSR_W-1:0] gpr_rdata,
  output logic [MSR_W-1:0] shd_rdata,
  output logic [MSR_W-1:0] msr_q,
  output logic [MSR_W-1:0] vec_prefix,
  output logic             ctx_flush,
  output logic             halt_req
);
  localparam logic [MSR_W-1:0] LEGAL =
    WMASK | RST_MSR | (SERVER64 ? FORCE_USER : '0);

  logic [MSR_W-1:0] nxt_msr;
  msr_evt_t         evt;

  msrc_filter #(
    .WMASK(WMASK), .EMB_MMU(EMB_MMU), .SERVER64(SERVER64), .SHADOW_EN(SHADOW_EN)
  ) u_filter (
    .cur_msr(msr_q), .wr_data(wr_data), .alter_hv(wr_alter_hv),
    .nxt_msr(nxt_msr), .evt(evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msr_q      <= RST_MSR;
      vec_prefix <= '0;
      ctx_flush  <= 1'b0;
    end else begin
      ctx_flush <= wr_valid && evt.flush;
      if (wr_valid) begin
        msr_q <= nxt_msr;
        if (evt.ep_chg) vec_prefix <= nxt_msr[B_EP] ? PREFIX_HI : '0;
      end
    end
  end

  msrc_bank #(.NREG(NREG), .W(MSR_W)) u_bank (
    .clk(clk), .rst(rst), .swap_i(wr_valid && evt.swap),
    .we_i(gpr_we), .waddr_i(gpr_waddr), .wdata_i(gpr_wdata),
    .raddr_i(gpr_raddr), .gpr_o(gpr_rdata), .shd_o(shd_rdata)
  );

  msrc_power u_power (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .pow_bit(nxt_msr[B_POW]),
    .irq_pending(irq_pending), .pwr_allowed(pwr_allowed), .halt_o(halt_req)
  );

  // R2
  mask_clean_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> (msr_q & ~LEGAL) == '0);
  // R3
  hv_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !(wr_alter_hv && msr_q[B_HV])) |=> msr_q[B_HV] == $past(msr_q[B_HV]));
  // R11
  flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> !ctx_flush && $stable(msr_q) && $stable(vec_prefix));
  // R7
  prefix_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_prefix == '0) || (vec_prefix == PREFIX_HI));
  // R8
  user_force_chk: assert property (@(posedge clk) disable iff (rst)
    (SERVER64 && wr_valid && wr_data[B_PR] && WMASK[B_PR])
      |=> msr_q[B_EE] && msr_q[B_IR] && msr_q[B_DR]);
endmodule

// File: tb/msr_write_ctrl_bench.sv
`timescale 1ns/1ps
module msr_write_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0, e_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic wr_alter_hv = 1'b0, irq_pending = 1'b0, pwr_allowed = 1'b0;
  logic gpr_we = 1'b0;
  logic [1:0] gpr_waddr = '0, gpr_raddr = '0;
  logic [31:0] gpr_wdata = '0;
  logic [31:0] gpr_rdata, shd_rdata, msr_q, vec_prefix;
  logic ctx_flush, halt_req;
  logic [31:0] e_gpr, e_shd, e_msr, e_pfx;
  logic e_flush, e_halt;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  msr_write_ctrl u_msr_write_ctrl (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_alter_hv(wr_alter_hv), .irq_pending(irq_pending), .pwr_allowed(pwr_allowed),
    .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata), .gpr_raddr(gpr_raddr),
    .gpr_rdata(gpr_rdata), .shd_rdata(shd_rdata), .msr_q(msr_q),
    .vec_prefix(vec_prefix), .ctx_flush(ctx_flush), .halt_req(halt_req));

  msr_write_ctrl #(.EMB_MMU(1'b1), .SERVER64(1'b0)) u_emb (
    .clk(clk), .rst(rst), .wr_valid(e_valid), .wr_data(wr_data),
    .wr_alter_hv(wr_alter_hv), .irq_pending(1'b0), .pwr_allowed(1'b0),
    .gpr_we(1'b0), .gpr_waddr(2'd0), .gpr_wdata(32'd0), .gpr_raddr(2'd0),
    .gpr_rdata(e_gpr), .shd_rdata(e_shd), .msr_q(e_msr),
    .vec_prefix(e_pfx), .ctx_flush(e_flush), .halt_req(e_halt));

  typedef struct packed {
    logic [31:0] data;
    logic        alter;
    logic [31:0] msr;
    logic        flush;
    logic [31:0] pfx;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'hFFFF_FFFF, 1'b1, 32'h1806_C071, 1'b1, 32'hFFF0_0000}, // R2 R7 mask + prefix set
    '{32'h0000_0000, 1'b0, 32'h1000_0000, 1'b1, 32'h0000_0000}, // R3 hv kept, R7 prefix clear
    '{32'h0000_0020, 1'b0, 32'h1000_0020, 1'b1, 32'h0000_0000}, // R4 IR on
    '{32'h0000_4000, 1'b0, 32'h1000_C030, 1'b1, 32'h0000_0000}, // R8 force, R4 pre-force compare
    '{32'h1000_C030, 1'b0, 32'h1000_C030, 1'b0, 32'h0000_0000}, // R4 no change, no flush
    '{32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1, 32'h0000_0000}, // R3 hv cleared with alter
    '{32'h1000_0000, 1'b1, 32'h0000_0000, 1'b0, 32'h0000_0000}, // R3 hv cannot be set from 0
    '{32'h8000_0001, 1'b0, 32'h0000_0001, 1'b0, 32'h0000_0000}  // R2 bit 31 dropped
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic msr_wr(input logic [31:0] d, input logic alt);
    @(negedge clk);
    wr_data = d; wr_alter_hv = alt; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic emb_wr(input logic [31:0] d);
    @(negedge clk);
    wr_data = d; wr_alter_hv = 1'b0; e_valid = 1'b1;
    @(negedge clk);
    e_valid = 1'b0;
  endtask

  task automatic gwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    gpr_we = 1'b1; gpr_waddr = a; gpr_wdata = d;
    @(negedge clk);
    gpr_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] eg, input logic [31:0] es, input string tag);
    gpr_raddr = a;
    #0.5;
    chk({tag, " gpr"}, gpr_rdata, eg);
    chk({tag, " shd"}, shd_rdata, es);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 msr", msr_q, 32'h1000_0000);
    chk("R1 prefix", vec_prefix, 32'h0);
    chk("R1 flush/halt", {30'd0, ctx_flush, halt_req}, 32'h0);
    for (int i = 0; i < 4; i++) rd(2'(i), 32'h0, 32'h0, "R1 bank");

    for (int k = 0; k < 8; k++) begin
      msr_wr(VECS[k].data, VECS[k].alter);
      chk($sformatf("R2/R3/R8 vec%0d msr", k), msr_q, VECS[k].msr);
      chk($sformatf("R4 vec%0d flush", k), {31'd0, ctx_flush}, {31'd0, VECS[k].flush});
      chk($sformatf("R7 vec%0d prefix", k), vec_prefix, VECS[k].pfx);
      @(negedge clk);
      chk($sformatf("R11 vec%0d flush one cycle", k), {31'd0, ctx_flush}, 32'h0);
    end

    // R11 idle: no write strobe
    @(negedge clk); wr_data = 32'hFFFF_FFFF; wr_alter_hv = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 idle msr", msr_q, 32'h0000_0001);
    chk("R11 idle flush", {31'd0, ctx_flush}, 32'h0);

    // R6 shadow swap
    for (int i = 0; i < 4; i++) gwr(2'(i), 32'hA0 + 32'(i));
    msr_wr(32'h0002_0001, 1'b0);
    chk("R6 swap msr", msr_q, 32'h0002_0001);
    for (int i = 0; i < 4; i++) rd(2'(i), 32'h0, 32'hA0 + 32'(i), "R6 swapped");
    msr_wr(32'h0002_0001, 1'b0);
    rd(2'd1, 32'h0, 32'hA1, "R6 no toggle");
    @(negedge clk);
    wr_data = 32'h0000_0001; wr_alter_hv = 1'b0; wr_valid = 1'b1;
    gpr_we = 1'b1; gpr_waddr = 2'd0; gpr_wdata = 32'hDEAD;
    @(negedge clk);
    wr_valid = 1'b0; gpr_we = 1'b0;
    rd(2'd0, 32'hA0, 32'h0, "R6 collide");

    // R5 guest-state bit on default build
    msr_wr(32'h0800_0001, 1'b0);
    chk("R5 default msr", msr_q, 32'h0800_0001);
    chk("R5 default no flush", {31'd0, ctx_flush}, 32'h0);

    // R9 / R10 halt
    irq_pending = 1'b0; pwr_allowed = 1'b1;
    msr_wr(32'h0004_0001, 1'b0);
    chk("R9 halt set", {31'd0, halt_req}, 32'h1);
    irq_pending = 1'b1;
    @(negedge clk);
    chk("R10 halt cleared by irq", {31'd0, halt_req}, 32'h0);
    msr_wr(32'h0004_0001, 1'b0);
    chk("R9 halt blocked by irq", {31'd0, halt_req}, 32'h0);
    irq_pending = 1'b0; pwr_allowed = 1'b0;
    msr_wr(32'h0004_0001, 1'b0);
    chk("R9 halt not allowed", {31'd0, halt_req}, 32'h0);
    pwr_allowed = 1'b1;
    msr_wr(32'h0004_0001, 1'b0);
    chk("R9 halt set again", {31'd0, halt_req}, 32'h1);
    msr_wr(32'h0000_0001, 1'b0);
    chk("R10 halt cleared by write", {31'd0, halt_req}, 32'h0);

    // R5 / R8 embedded non-server build
    emb_wr(32'h0800_0000);
    chk("R5 emb msr", e_msr, 32'h1800_0000);
    chk("R5 emb flush", {31'd0, e_flush}, 32'h1);
    emb_wr(32'h1800_4000);
    chk("R8 emb no force", e_msr, 32'h1800_4000);
    chk("R8 emb no flush", {31'd0, e_flush}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule